// File: doc/BRIEF.md
# Serial Flash Fast-Read Target

This block is the target side of a four-wire serial link (active-low select, serial clock, data in, data out) that answers one command: a high-speed read. The host lowers the select line and shifts in a command byte, three address bytes and one padding byte. The block then returns bytes from its internal array, one after another, for as long as the host keeps clocking. After each byte it moves to the next location. Past the top of the array it starts again at location zero. Raising the select line ends the transfer at any point.

All logic runs on a fast system clock. The three link inputs pass through synchronizers, and serial clock edges are found by comparing successive samples. The array is a register file. A separate write port fills it for test. A busy input marks an erase, program or write cycle in progress. While it is high, a read command is refused and the output stays released. The output is given as a data bit plus an enable, and the enable stands for the high-impedance control.

Top module: `spi_fast_read_responder`

## Requirements
- R1: After `csN` rises, `misoOe` is low within 4 system clocks and stays low while `csN` stays high. This holds even when `csN` rises in the middle of a data byte.
- R2: The bits on `mosi` are taken on rising `sclk` edges, MSB first: 8 command bits, then 24 address bits, then 8 padding bits. The padding value has no effect on the data returned.
- R3: `misoOe` is low during the first 40 rising `sclk` edges of a transfer. The first data bit is driven after the falling edge that follows rising edge 40. Each byte is sent MSB first.
- R4: After each byte, the next byte comes from the next higher array location.
- R5: After location 2^ADDR_W-1 the read continues at location 0, with no limit on the transfer length.
- R6: Address bits at and above bit ADDR_W are ignored.
- R7: If `busy` is high when the command byte completes, no data is returned (`misoOe` stays low) until `csN` rises.
- R8: A command code other than 8'h0B returns no data (`misoOe` stays low) until `csN` rises.
- R9: When `preloadEn` is high at a system clock edge, `preloadData` is written to location `preloadAddr`. A later read returns that value.
- R10: `misoData` changes only after falling `sclk` edges. It holds steady while `sclk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low select of the serial link |
| sclk | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data into the target |
| busy | input | 1 | An erase, program or write cycle is in progress |
| preloadEn | input | 1 | Write strobe of the test write port |
| preloadAddr | input | ADDR_W | Location written by the test write port |
| preloadData | input | 8 | Byte written by the test write port |
| misoData | output | 1 | Serial data out of the target |
| misoOe | output | 1 | Output enable; low means high impedance |

## Verification
A change on a link input reaches the outputs about three system clocks later: two synchronizer stages, then one register for the edge detect and the state. The output is released within that delay of `csN` rising. A data bit is valid within that delay of the falling serial edge that launches it. The bench holds each serial clock phase for 8 system clocks. It samples `misoData` and `misoOe` at its own rising serial edge, which is a full half period after the falling edge. It checks the released state 5 system clocks after raising `csN`. As a result, no check depends on the exact synchronizer delay.

// File: rtl/frd_pkg.sv
package frd_pkg;
  localparam logic [7:0] FAST_READ_CODE = 8'h0B;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_IGNORE
  } frdState_t;

  typedef struct packed {
    logic shiftIn;   // take one bit from mosi
    logic capAddr;   // last address bit arrives: load pointer
    logic fetch;     // prefetch first byte
    logic shiftOut;  // falling edge in data phase
    logic endTx;     // select released
  } frdStrobe_t;
endpackage

// File: rtl/frd_sync.sv
module frd_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      for (int i = 0; i < STAGES; i++) begin
        if (i == 0) stg[i] <= din;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/frd_ctrl.sv
module frd_ctrl
  import frd_pkg::*;
#(
  parameter int HEAD_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csS,
  input  logic              sclkS,
  input  logic              mosiS,
  input  logic              busy,
  input  logic [HEAD_W-1:0] cmdHead,
  output frdStrobe_t        strobe
);
  frdState_t  state;
  logic [4:0] cnt;
  logic       sclkQ;
  logic       fetchQ;
  logic       rise, fall;
  logic [7:0] cmdByte;

  assign rise    = sclkS & ~sclkQ;
  assign fall    = ~sclkS & sclkQ;
  assign cmdByte = {cmdHead[6:0], mosiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sclkQ  <= 1'b0;
      fetchQ <= 1'b0;
    end else begin
      sclkQ  <= sclkS;
      fetchQ <= strobe.capAddr;
      if (csS) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            state <= ST_CMD;
            cnt   <= '0;
          end
          ST_CMD: if (rise) begin
            if (cnt == 5'd7) begin
              cnt   <= '0;
              state <= (cmdByte == FAST_READ_CODE && !busy) ? ST_ADDR : ST_IGNORE;
            end else cnt <= cnt + 5'd1;
          end
          ST_ADDR: if (rise) begin
            if (cnt == 5'd23) begin
              cnt   <= '0;
              state <= ST_DUMMY;
            end else cnt <= cnt + 5'd1;
          end
          ST_DUMMY: if (rise) begin
            if (cnt == 5'd7) begin
              cnt   <= '0;
              state <= ST_DATA;
            end else cnt <= cnt + 5'd1;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strobe.shiftIn  = rise && !csS && (state == ST_CMD || state == ST_ADDR);
    strobe.capAddr  = rise && !csS && state == ST_ADDR && cnt == 5'd23;
    strobe.fetch    = fetchQ;
    strobe.shiftOut = fall && !csS && state == ST_DATA;
    strobe.endTx    = csS;
  end
endmodule

// File: rtl/frd_datapath.sv
module frd_datapath
  import frd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HEAD_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  frdStrobe_t        strobe,
  input  logic              mosiS,
  input  logic              preloadEn,
  input  logic [ADDR_W-1:0] preloadAddr,
  input  logic [7:0]        preloadData,
  output logic [HEAD_W-1:0] cmdHead,
  output logic              misoData,
  output logic              misoOe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        mem [DEPTH];
  logic [HEAD_W-1:0] inShift;
  logic [ADDR_W-1:0] addrPtr;
  logic [7:0]        txShift;
  logic [2:0]        outCnt;
  logic [7:0]        readByte;

  always_ff @(posedge clk) begin
    if (preloadEn) mem[preloadAddr] <= preloadData;
  end

  assign readByte = mem[addrPtr];
  assign cmdHead  = inShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift  <= '0;
      addrPtr  <= '0;
      txShift  <= '0;
      outCnt   <= '0;
      misoData <= 1'b0;
      misoOe   <= 1'b0;
    end else begin
      if (strobe.shiftIn) inShift <= {inShift[HEAD_W-2:0], mosiS};
      if (strobe.capAddr) addrPtr <= {inShift[ADDR_W-2:0], mosiS};
      if (strobe.endTx) begin
        misoOe <= 1'b0;
        outCnt <= '0;
      end else if (strobe.fetch) begin
        txShift <= readByte;
        addrPtr <= addrPtr + ADDR_W'(1);
        outCnt  <= '0;
      end else if (strobe.shiftOut) begin
        misoData <= txShift[7];
        misoOe   <= 1'b1;
        outCnt   <= outCnt + 3'd1;
        if (outCnt == 3'd7) begin
          txShift <= readByte;
          addrPtr <= addrPtr + ADDR_W'(1);
        end else begin
          txShift <= {txShift[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_fast_read_responder.sv
module spi_fast_read_responder
  import frd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              busy,
  input  logic              preloadEn,
  input  logic [ADDR_W-1:0] preloadAddr,
  input  logic [7:0]        preloadData,
  output logic              misoData,
  output logic              misoOe
);
  localparam int HEAD_W = (ADDR_W - 1 > 7) ? ADDR_W - 1 : 7;

  logic [2:0]        syncOut;
  frdStrobe_t        strobe;
  logic [HEAD_W-1:0] cmdHead;

  frd_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rstN(rstN), .din({csN, sclk, mosi}), .dout(syncOut)
  );

  frd_ctrl #(.HEAD_W(HEAD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csS(syncOut[2]), .sclkS(syncOut[1]),
    .mosiS(syncOut[0]), .busy(busy), .cmdHead(cmdHead), .strobe(strobe)
  );

  frd_datapath #(.ADDR_W(ADDR_W), .HEAD_W(HEAD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mosiS(syncOut[0]),
    .preloadEn(preloadEn), .preloadAddr(preloadAddr), .preloadData(preloadData),
    .cmdHead(cmdHead), .misoData(misoData), .misoOe(misoOe)
  );
endmodule

// File: rtl/frd_checker.sv
module frd_checker (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sclk,
  input logic mosi,
  input logic busy,
  input logic misoData,
  input logic misoOe
);
  logic       sclkQ;
  logic [6:0] riseCnt;
  logic [7:0] cmdSh;
  logic       rejectQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ   <= 1'b0;
      riseCnt <= '0;
      cmdSh   <= '0;
      rejectQ <= 1'b0;
    end else begin
      sclkQ <= sclk;
      if (csN) begin
        riseCnt <= '0;
        rejectQ <= 1'b0;
      end else if (sclk && !sclkQ) begin
        if (riseCnt != 7'd100) riseCnt <= riseCnt + 7'd1;
        if (riseCnt < 7'd8) cmdSh <= {cmdSh[6:0], mosi};
        if (riseCnt == 7'd7) rejectQ <= ({cmdSh[6:0], mosi} != 8'h0B) || busy;
      end
    end
  end

  // R1: released select keeps the output released
  a_r1_release: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !misoOe);

  // R3: no output before the 40th rising serial edge
  a_r3_no_early_output: assert property (@(posedge clk) disable iff (!rstN)
    $rose(misoOe) |-> (riseCnt >= 7'd40));

  // R7, R8: refused command keeps the output released
  a_r7_r8_refused: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && riseCnt >= 7'd9 && rejectQ) |-> !misoOe);

  // R10: data holds while the serial clock is high
  a_r10_hold_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk) && $past(sclk, 2) && $past(sclk, 3) && $past(sclk, 4))
      |-> $stable(misoData));
endmodule

bind spi_fast_read_responder frd_checker u_chk (.*);

// File: tb/test_spi_fast_read_responder.sv
module test_spi_fast_read_responder;
  localparam int CLK_PERIOD = 10;
  localparam int SCLK_HALF  = 8;
  localparam int ADDR_W     = 8;
  localparam int DEPTH      = 1 << ADDR_W;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, mosi = 1'b0, busy = 1'b0;
  logic preloadEn = 1'b0;
  logic [ADDR_W-1:0] preloadAddr = '0;
  logic [7:0] preloadData = '0;
  logic misoData, misoOe;

  int checks = 0;
  int errors = 0;
  expItem_t q[$];
  logic [7:0] model [DEPTH];
  bit expectData = 1'b0;
  string rejectTag = "R7";
  int riseIdx = 0;
  int bitCnt = 0;
  logic [7:0] acc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fast_read_responder #(.ADDR_W(ADDR_W)) i_spi_fast_read_responder (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi), .busy(busy),
    .preloadEn(preloadEn), .preloadAddr(preloadAddr), .preloadData(preloadData),
    .misoData(misoData), .misoOe(misoOe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic preload(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    preloadEn = 1'b1; preloadAddr = a; preloadData = d;
    @(negedge clk);
    preloadEn = 1'b0;
    model[a] = d;
  endtask

  // driver: pushes expected bytes, then plays the transfer
  task automatic xfer(input logic [7:0] cmd, input logic [23:0] addr,
                      input logic [7:0] dummy, input logic busyV,
                      input int nBytes, input int extraBits, input string tag);
    logic [39:0] hdr;
    bit accept;
    hdr = {cmd, addr, dummy};
    accept = (cmd == 8'h0B) && !busyV;
    if (accept) begin
      for (int k = 0; k < nBytes; k++) begin
        expItem_t it;
        it.val = model[addr[ADDR_W-1:0] + ADDR_W'(k)];
        it.tag = tag;
        q.push_back(it);
      end
    end
    expectData = accept;
    rejectTag  = tag;
    @(negedge clk);
    busy = busyV;
    csN  = 1'b0;
    repeat (4) @(negedge clk);
    for (int b = 0; b < 40 + nBytes * 8 + extraBits; b++) begin
      mosi = (b < 40) ? hdr[39-b] : 1'b0;
      repeat (SCLK_HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (SCLK_HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (SCLK_HALF) @(negedge clk);
    csN = 1'b1;
    repeat (5) @(negedge clk);
    check(misoOe === 1'b0, "R1", "output released after select high", int'(misoOe), 0);
    check(q.size() == 0, tag, "expected bytes left over", q.size(), 0);
    q.delete();
    busy = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // monitor: samples at the bench's rising serial edge
  initial begin
    forever begin
      @(posedge sclk or posedge csN);
      if (csN) begin
        riseIdx = 0;
        bitCnt  = 0;
      end else begin
        riseIdx++;
        if (riseIdx <= 40) begin
          check(misoOe === 1'b0, "R3", "output during header", int'(misoOe), 0);
        end else if (!expectData) begin
          check(misoOe === 1'b0, rejectTag, "output after refused command", int'(misoOe), 0);
        end else begin
          check(misoOe === 1'b1, "R3", "output enabled in data phase", int'(misoOe), 1);
          acc = {acc[6:0], misoData};
          bitCnt++;
          if (bitCnt == 8) begin
            bitCnt = 0;
            if (q.size() == 0) begin
              check(1'b0, "R4", "unexpected byte", int'(acc), 0);
            end else begin
              expItem_t it;
              it = q.pop_front();
              check(acc === it.val, it.tag, "data byte", int'(acc), int'(it.val));
            end
          end
        end
      end
    end
  end

  // R10: data holds through the high half of the serial clock
  initial begin
    forever begin
      logic v;
      @(posedge sclk);
      v = misoData;
      @(negedge sclk);
      if (!csN && expectData && riseIdx > 40)
        check(misoData === v, "R10", "data moved while sclk high", int'(misoData), int'(v));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(misoOe === 1'b0, "R1", "reset output released", int'(misoOe), 0);
    for (int i = 0; i < DEPTH; i++) preload(ADDR_W'(i), 8'(i * 37 + 11) ^ 8'hA5);

    xfer(8'h0B, 24'h000010, 8'h00, 1'b0, 4, 0, "R2");
    xfer(8'h0B, 24'h000080, 8'hFF, 1'b0, 3, 0, "R4");
    xfer(8'h0B, 24'h0000FD, 8'h5A, 1'b0, 5, 0, "R5");
    xfer(8'h0B, 24'hABCD05, 8'h3C, 1'b0, 3, 0, "R6");
    xfer(8'h0B, 24'h000020, 8'h00, 1'b1, 2, 0, "R7");
    xfer(8'h03, 24'h000020, 8'h00, 1'b0, 2, 0, "R8");
    xfer(8'h0B, 24'h000040, 8'h00, 1'b0, 1, 3, "R1");
    preload(ADDR_W'(8'h50), 8'hC3);
    xfer(8'h0B, 24'h000050, 8'h00, 1'b0, 1, 0, "R9");
    xfer(8'h0B, 24'h000000, 8'hA5, 1'b0, DEPTH + 4, 0, "R5");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule